// File: doc/BRIEF.md
# Circular Message Frame Queue Manager

This block keeps four circular queues of 32-bit message frame addresses in an internal storage array. Two queues serve the inbound direction: a free list of frames the host may claim, and a post list of frames the host has filled. The other two serve the outbound direction: frames the local processor has filled for the host, and frames the host hands back. A single request bus carries both host accesses and local processor accesses. The bus reaches two queue ports, eight pointer registers, a control register, a base register and a direct storage window.

A read of a queue port pops one queue and returns the address at that queue's tail. A write to the same port pushes the data onto a different queue at its head. A pop from an empty queue, or any port access while the unit is disabled, returns the all-ones sentinel and moves no pointer. The local processor fills and drains its side of each queue in two steps. It reads and writes entries through the storage window, and it then moves the matching head or tail pointer with a register write.

Top module: `mfq_manager`

## Requirements
- R1: After reset the control register reads 0, every pointer register reads the base with a zero index, and all three interrupt outputs are low.
- R2: The base register (byte address 0x170) ignores the written bits 19:0 and reads them as zero. A pointer register reads as base OR (queue number × entries × 4) OR (index × 4). The queue numbers are: inbound free 0, inbound post 1, outbound free 2, outbound post 3.
- R3: A read of the inbound port (0x040) returns the inbound free entry at the tail, and the tail advances by one entry. Repeated reads return entries in the order they were placed. The inbound free head is at 0x120 and its tail is at 0x128.
- R4: A write to the inbound port stores the data at the inbound post head and advances that head. The inbound post head is at 0x130 and its tail is at 0x138.
- R5: A read of the outbound port (0x044) pops the outbound post queue, whose head is at 0x150 and tail at 0x158. A write to the outbound port pushes the outbound free queue, whose head is at 0x140 and tail at 0x148.
- R6: A port read from a queue whose head equals its tail returns 0xFFFFFFFF and leaves that tail unchanged.
- R7: A port write that would make head equal tail is dropped and sets a sticky overflow flag (control bit 8). The flag drives irq_overflow when control bit 5 is set. Writing 1 to control bit 8 clears the flag.
- R8: irq_inpost_ne is high while the inbound post queue is not empty, and irq_outpost_ne is high while the outbound post queue is not empty. Each is high only when the unit is enabled (control bit 0) and the not-empty interrupt enable (control bit 4) is set.
- R9: Head and tail pointers wrap from the last entry of their queue to entry 0.
- R10: Control bits 3:1 give a size code c, and each queue then holds 2^(MIN_LG+c) entries. A code above NUM_SIZES-1 acts as NUM_SIZES-1. The four queue regions follow one another from the base in queue-number order.
- R11: While control bit 0 is clear, port reads return 0xFFFFFFFF and pop nothing, and port writes change no pointer.
- R12: Every read request gets exactly one response on the next cycle, and write requests get none.
- R13: A bus address with bit 15 set reaches storage word (queue number × 2^IDX_W + index) directly. That word is taken from address bits [IDX_W+3:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid, one cycle after the read request |
| rsp_rdata | output | DATA_W | Read response data |
| irq_inpost_ne | output | 1 | Inbound post queue holds entries (local processor interrupt) |
| irq_outpost_ne | output | 1 | Outbound post queue holds entries (host interrupt) |
| irq_overflow | output | 1 | A port push was dropped on a full queue |

## Verification
The bench pops a queue until it is empty and expects the sentinel and a tail that has not moved. A design that pops anyway would return stale storage and lose an entry. It fills the outbound free queue to one entry short of its size and then pushes once more. A design with the wrong full test would either raise overflow one push early or overwrite the tail entry without a report. It parks the outbound post pointers on the last entry to force a wrap, changes the size code with live pointers, and uses a code above the largest size. Wrong wrap or size logic shows as a bad pointer readback or a frame returned out of order. With the unit disabled it also sends port reads and writes at queues that hold data or have room. A leaky enable would then pop a real frame or move a head.

// File: rtl/mfq_pkg.sv
package mfq_pkg;
   // byte addresses on the request bus
   localparam int A_INPORT  = 'h040;
   localparam int A_OUTPORT = 'h044;
   localparam int A_CTRL    = 'h164;
   localparam int A_BASE    = 'h170;

   // queue numbers; storage regions follow this order
   localparam logic [1:0] QN_IN_FREE  = 2'd0;
   localparam logic [1:0] QN_IN_POST  = 2'd1;
   localparam logic [1:0] QN_OUT_FREE = 2'd2;
   localparam logic [1:0] QN_OUT_POST = 2'd3;

   // control register bit positions
   localparam int CB_EN      = 0;
   localparam int CB_SIZE_LO = 1;
   localparam int CB_NE_EN   = 4;
   localparam int CB_OVF_EN  = 5;
   localparam int CB_OVF     = 8;

   localparam int BASE_ALIGN_LG = 20;

   typedef enum logic [1:0] {
      RS_REG  = 2'd0,
      RS_MEM  = 2'd1,
      RS_SENT = 2'd2
   } rsp_src_e;
endpackage

// File: rtl/mfq_ptr_bank.sv
module mfq_ptr_bank #(
   parameter int IDX_W = 8,
   parameter int NQ    = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IDX_W-1:0]          mask,
   input  logic [NQ-1:0]             push,
   input  logic [NQ-1:0]             pop,
   input  logic [NQ-1:0]             ld_head,
   input  logic [NQ-1:0]             ld_tail,
   input  logic [IDX_W-1:0]          ld_val,
   output logic [NQ-1:0][IDX_W-1:0]  head,
   output logic [NQ-1:0][IDX_W-1:0]  tail,
   output logic [NQ-1:0]             empty,
   output logic [NQ-1:0]             full
);
   for (genvar g = 0; g < NQ; g++) begin : g_q
      logic [IDX_W-1:0] hd_r, tl_r, hd_m, tl_m, hd_nx, tl_nx;

      assign hd_m  = hd_r & mask;
      assign tl_m  = tl_r & mask;
      assign hd_nx = (hd_m + IDX_W'(1)) & mask;
      assign tl_nx = (tl_m + IDX_W'(1)) & mask;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hd_r <= '0;
            tl_r <= '0;
         end else begin
            if (ld_head[g])   hd_r <= ld_val & mask;
            else if (push[g]) hd_r <= hd_nx;
            if (ld_tail[g])   tl_r <= ld_val & mask;
            else if (pop[g])  tl_r <= tl_nx;
         end
      end

      assign head[g]  = hd_m;
      assign tail[g]  = tl_m;
      assign empty[g] = (hd_m == tl_m);
      assign full[g]  = (hd_nx == tl_m);
   end
endmodule

// File: rtl/mfq_store.sv
module mfq_store #(
   parameter int DW = 32,
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/mfq_cfg.sv
module mfq_cfg #(
   parameter int NUM_SIZES = 5
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_ctrl,
   input  logic        wr_base,
   input  logic [31:0] wdata,
   input  logic        ovf_set,
   output logic        en,
   output logic        ne_en,
   output logic        ovf_en,
   output logic        ovf_flag,
   output logic [2:0]  size_code,
   output logic [31:0] ctrl_rd,
   output logic [31:0] base
);
   import mfq_pkg::*;
   localparam logic [2:0] MAX_CODE = 3'(NUM_SIZES - 1);

   logic [2:0] size_raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en       <= 1'b0;
         ne_en    <= 1'b0;
         ovf_en   <= 1'b0;
         size_raw <= '0;
         ovf_flag <= 1'b0;
         base     <= '0;
      end else begin
         if (wr_ctrl) begin
            en       <= wdata[CB_EN];
            ne_en    <= wdata[CB_NE_EN];
            ovf_en   <= wdata[CB_OVF_EN];
            size_raw <= wdata[CB_SIZE_LO +: 3];
         end
         if (ovf_set)                      ovf_flag <= 1'b1;
         else if (wr_ctrl && wdata[CB_OVF]) ovf_flag <= 1'b0;
         if (wr_base)
            base <= {wdata[31:BASE_ALIGN_LG], {BASE_ALIGN_LG{1'b0}}};
      end
   end

   assign size_code = (size_raw > MAX_CODE) ? MAX_CODE : size_raw;
   assign ctrl_rd   = {23'd0, ovf_flag, 2'b00, ovf_en, ne_en, size_raw, en};
endmodule

// File: rtl/mfq_manager.sv
module mfq_manager
   import mfq_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 32,
   parameter int MIN_LG    = 4,
   parameter int NUM_SIZES = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              irq_inpost_ne,
   output logic              irq_outpost_ne,
   output logic              irq_overflow
);
   localparam int NQ     = 4;
   localparam int IDX_W  = MIN_LG + NUM_SIZES - 1;
   localparam int MEM_AW = IDX_W + 2;

   if (DATA_W != 32) begin : g_bad_dw
      $error("mfq_manager: DATA_W must be 32");
   end
   if (NUM_SIZES < 1 || NUM_SIZES > 8) begin : g_bad_sizes
      $error("mfq_manager: NUM_SIZES must be 1..8");
   end
   if (MEM_AW + 3 > ADDR_W) begin : g_bad_aw
      $error("mfq_manager: ADDR_W too narrow for the storage window");
   end
   if (IDX_W + 4 > BASE_ALIGN_LG) begin : g_bad_align
      $error("mfq_manager: queue regions exceed the base alignment");
   end

   // ---------------- decode ----------------
   logic rd_req, wr_req, win, hit_in, hit_out, hit_port, hit_ctrl, hit_base;
   logic ptr_hit, ptr_tail;
   logic [1:0] ptr_q;
   logic [3:0] ptr_nib;

   assign rd_req   = req_valid & ~req_write;
   assign wr_req   = req_valid &  req_write;
   assign win      = req_addr[ADDR_W-1];
   assign hit_in   = (req_addr == ADDR_W'(A_INPORT));
   assign hit_out  = (req_addr == ADDR_W'(A_OUTPORT));
   assign hit_port = hit_in | hit_out;
   assign hit_ctrl = (req_addr == ADDR_W'(A_CTRL));
   assign hit_base = (req_addr == ADDR_W'(A_BASE));
   assign ptr_nib  = req_addr[7:4];
   assign ptr_hit  = (req_addr[ADDR_W-1:8] == (ADDR_W-8)'(1)) &&
                     (ptr_nib >= 4'd2) && (ptr_nib <= 4'd5) &&
                     (req_addr[2:0] == 3'd0);
   assign ptr_tail = req_addr[3];
   assign ptr_q    = ptr_nib[1:0] + 2'd2;

   // ---------------- configuration ----------------
   logic        q_en, ne_en, ovf_en, ovf_flag, ovf_set;
   logic [2:0]  size_code;
   logic [31:0] ctrl_rd, base_q;

   mfq_cfg #(.NUM_SIZES(NUM_SIZES)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_ctrl  (wr_req & hit_ctrl),
      .wr_base  (wr_req & hit_base),
      .wdata    (req_wdata),
      .ovf_set  (ovf_set),
      .en       (q_en),
      .ne_en    (ne_en),
      .ovf_en   (ovf_en),
      .ovf_flag (ovf_flag),
      .size_code(size_code),
      .ctrl_rd  (ctrl_rd),
      .base     (base_q)
   );

   logic [IDX_W-1:0] size_mask;
   assign size_mask = {IDX_W{1'b1}} >> (3'(NUM_SIZES - 1) - size_code);

   // ---------------- pointers ----------------
   logic [NQ-1:0][IDX_W-1:0] q_head, q_tail;
   logic [NQ-1:0] q_empty, q_full, push_vec, pop_vec, ldh_vec, ldt_vec;
   logic [1:0] pop_q, push_q;
   logic do_pop, try_push, do_push;

   assign pop_q    = hit_in ? QN_IN_FREE : QN_OUT_POST;
   assign push_q   = hit_in ? QN_IN_POST : QN_OUT_FREE;
   assign do_pop   = rd_req & hit_port & q_en & ~q_empty[pop_q];
   assign try_push = wr_req & hit_port & q_en;
   assign do_push  = try_push & ~q_full[push_q];
   assign ovf_set  = try_push &  q_full[push_q];

   assign push_vec = do_push ? (NQ'(1) << push_q) : '0;
   assign pop_vec  = do_pop  ? (NQ'(1) << pop_q)  : '0;
   assign ldh_vec  = (wr_req & ptr_hit & ~ptr_tail) ? (NQ'(1) << ptr_q) : '0;
   assign ldt_vec  = (wr_req & ptr_hit &  ptr_tail) ? (NQ'(1) << ptr_q) : '0;

   mfq_ptr_bank #(.IDX_W(IDX_W), .NQ(NQ)) u_ptr (
      .clk    (clk),
      .rst_n  (rst_n),
      .mask   (size_mask),
      .push   (push_vec),
      .pop    (pop_vec),
      .ld_head(ldh_vec),
      .ld_tail(ldt_vec),
      .ld_val (req_wdata[IDX_W+1:2]),
      .head   (q_head),
      .tail   (q_tail),
      .empty  (q_empty),
      .full   (q_full)
   );

   // ---------------- storage ----------------
   logic              mem_we, mem_re;
   logic [MEM_AW-1:0] mem_waddr, mem_raddr;
   logic [DATA_W-1:0] mem_rdata;

   assign mem_we    = do_push | (wr_req & win);
   assign mem_re    = do_pop  | (rd_req & win);
   assign mem_waddr = win ? req_addr[MEM_AW+1:2] : {push_q, q_head[push_q]};
   assign mem_raddr = win ? req_addr[MEM_AW+1:2] : {pop_q,  q_tail[pop_q]};

   mfq_store #(.DW(DATA_W), .AW(MEM_AW)) u_store (
      .clk  (clk),
      .we   (mem_we),
      .waddr(mem_waddr),
      .wdata(req_wdata),
      .re   (mem_re),
      .raddr(mem_raddr),
      .rdata(mem_rdata)
   );

   // ---------------- register reads ----------------
   logic [IDX_W-1:0] ptr_idx;
   logic [31:0]      ptr_val, reg_val;

   assign ptr_idx = ptr_tail ? q_tail[ptr_q] : q_head[ptr_q];
   assign ptr_val = base_q
                  | (32'(ptr_q) << (32'(size_code) + 32'(MIN_LG) + 32'd2))
                  | (32'(ptr_idx) << 2);

   always_comb begin
      reg_val = '0;
      if (hit_ctrl)     reg_val = ctrl_rd;
      else if (hit_base) reg_val = base_q;
      else if (ptr_hit)  reg_val = ptr_val;
   end

   // ---------------- response ----------------
   rsp_src_e    rsp_src;
   logic [31:0] rsp_reg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_src   <= RS_REG;
         rsp_reg   <= '0;
      end else begin
         rsp_valid <= rd_req;
         if (rd_req) begin
            rsp_reg <= reg_val;
            if (win || do_pop) rsp_src <= RS_MEM;
            else if (hit_port) rsp_src <= RS_SENT;
            else               rsp_src <= RS_REG;
         end
      end
   end

   always_comb begin
      case (rsp_src)
         RS_MEM:  rsp_rdata = mem_rdata;
         RS_SENT: rsp_rdata = '1;
         default: rsp_rdata = rsp_reg;
      endcase
   end

   // ---------------- interrupts ----------------
   assign irq_inpost_ne  = q_en & ne_en & ~q_empty[QN_IN_POST];
   assign irq_outpost_ne = q_en & ne_en & ~q_empty[QN_OUT_POST];
   assign irq_overflow   = ovf_en & ovf_flag;
endmodule

// File: rtl/mfq_checker.sv
module mfq_checker #(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 8,
   parameter int NQ     = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     req_valid,
   input logic                     req_write,
   input logic [ADDR_W-1:0]        req_addr,
   input logic                     rsp_valid,
   input logic [31:0]              rsp_rdata,
   input logic                     irq_inpost_ne,
   input logic                     irq_outpost_ne,
   input logic                     irq_overflow,
   input logic                     q_en,
   input logic [NQ-1:0][IDX_W-1:0] q_tail,
   input logic [NQ-1:0]            q_empty
);
   import mfq_pkg::*;

   logic rd_now, port_now;
   assign rd_now   = req_valid && !req_write;
   assign port_now = (req_addr == ADDR_W'(A_INPORT)) || (req_addr == ADDR_W'(A_OUTPORT));

   // R12
   rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_now |=> rsp_valid);

   // R12
   rsp_only_for_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_now |=> !rsp_valid);

   // R6
   empty_pop_sentinel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && req_addr == ADDR_W'(A_INPORT) && q_en && q_empty[QN_IN_FREE])
      |=> (rsp_rdata == 32'hFFFF_FFFF));

   // R11
   idle_port_no_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_now && port_now && !q_en) |=> $stable(q_tail));

   // R8
   ne_irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_inpost_ne || irq_outpost_ne) |-> q_en);

   // R7
   ovf_rise_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_overflow) |-> $past(req_valid && req_write));
endmodule

bind mfq_manager mfq_checker #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NQ(NQ)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_write     (req_write),
   .req_addr      (req_addr),
   .rsp_valid     (rsp_valid),
   .rsp_rdata     (rsp_rdata),
   .irq_inpost_ne (irq_inpost_ne),
   .irq_outpost_ne(irq_outpost_ne),
   .irq_overflow  (irq_overflow),
   .q_en          (q_en),
   .q_tail        (q_tail),
   .q_empty       (q_empty)
);

// File: tb/mfq_manager_bench.sv
`timescale 1ns/1ps
module mfq_manager_bench;
   localparam logic [15:0] INP  = 16'h0040, OUTP = 16'h0044;
   localparam logic [15:0] IFH  = 16'h0120, IFT = 16'h0128;
   localparam logic [15:0] IPH  = 16'h0130, IPT = 16'h0138;
   localparam logic [15:0] OFH  = 16'h0140;
   localparam logic [15:0] OPH  = 16'h0150, OPT = 16'h0158;
   localparam logic [15:0] CTRL = 16'h0164, BASE = 16'h0170;
   localparam logic [31:0] SENT = 32'hFFFF_FFFF;
   localparam logic [31:0] B    = 32'h1230_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [15:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        irq_inpost_ne, irq_outpost_ne, irq_overflow;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   logic [31:0] exp_val[$];
   string       exp_tag[$];

   always #2 clk = ~clk;

   mfq_manager u_mfq_manager (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .irq_inpost_ne(irq_inpost_ne),
      .irq_outpost_ne(irq_outpost_ne), .irq_overflow(irq_overflow)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, input logic [31:0] e, input string tag);
      exp_val.push_back(e);
      exp_tag.push_back(tag);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_val.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12: actual unexpected response %h expected none", rsp_rdata);
         end else begin
            chk(exp_tag.pop_front(), rsp_rdata, exp_val.pop_front());
         end
      end
   end

   task automatic finish_run();
      if (exp_val.size() != 0) begin
         n_chk++; n_fail++;
         $display("FAIL R12: actual %0d responses missing expected 0", exp_val.size());
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 irq_in", {31'd0, irq_inpost_ne}, 0);
      chk("R1 irq_out", {31'd0, irq_outpost_ne}, 0);
      chk("R1 irq_ovf", {31'd0, irq_overflow}, 0);
      rd(CTRL, 32'h0, "R1 ctrl");
      rd(IFH, 32'h0, "R1 ptr");
      // R11 disabled port access
      rd(INP, SENT, "R11 disabled read");
      wr(INP, 32'h55);
      chk("R12 no rsp on write", {31'd0, rsp_valid}, 0);
      // R2 base alignment
      wr(BASE, 32'h1234_5678);
      rd(BASE, B, "R2 base");
      rd(IPH, B | 32'h40, "R11 write ignored / R2 region");
      // enable, size code 0, ne and ovf enables
      wr(CTRL, 32'h31);
      rd(CTRL, 32'h31, "R10 ctrl readback");
      rd(INP, SENT, "R6 empty pop");
      rd(IFT, B, "R6 tail unchanged");
      // R3 / R13 inbound free fill and pop
      wr(16'h8000, 32'hA0A0_0001);
      wr(16'h8004, 32'hA0A0_0002);
      wr(16'h8008, 32'hA0A0_0003);
      wr(IFH, 32'h0C);
      rd(INP, 32'hA0A0_0001, "R3 pop0");
      rd(INP, 32'hA0A0_0002, "R3 pop1");
      rd(INP, 32'hA0A0_0003, "R3 pop2");
      rd(INP, SENT, "R6 drained");
      rd(IFT, B | 32'h0C, "R3 tail");
      // R4 inbound post
      wr(INP, 32'hB0B0_0001);
      wr(INP, 32'hB0B0_0002);
      chk("R8 inpost ne", {31'd0, irq_inpost_ne}, 1);
      rd(16'h8400, 32'hB0B0_0001, "R4 R13 entry0");
      rd(16'h8404, 32'hB0B0_0002, "R4 R13 entry1");
      rd(IPH, B | 32'h48, "R4 head");
      wr(IPT, 32'h08);
      chk("R8 inpost drained", {31'd0, irq_inpost_ne}, 0);
      // R7 overflow on outbound free
      for (int i = 0; i < 15; i++) wr(OUTP, 32'hF000_0000 + 32'(i));
      chk("R7 no ovf at capacity", {31'd0, irq_overflow}, 0);
      wr(OUTP, 32'hF000_00FF);
      chk("R7 ovf raised", {31'd0, irq_overflow}, 1);
      rd(OFH, B | 32'hBC, "R7 head held");
      rd(16'h8838, 32'hF000_000E, "R5 out free last entry");
      wr(CTRL, 32'h131);
      chk("R7 ovf cleared", {31'd0, irq_overflow}, 0);
      rd(CTRL, 32'h31, "R7 ctrl after clear");
      // R5 outbound post
      wr(16'h8C00, 32'hC0C0_0001);
      wr(OPH, 32'h04);
      chk("R8 outpost ne", {31'd0, irq_outpost_ne}, 1);
      rd(OUTP, 32'hC0C0_0001, "R5 out pop");
      rd(OUTP, SENT, "R6 out empty");
      chk("R8 outpost drained", {31'd0, irq_outpost_ne}, 0);
      // R9 wrap
      wr(OPH, 32'h3C);
      wr(OPT, 32'h3C);
      wr(16'h8C3C, 32'hD0D0_0001);
      wr(16'h8C00, 32'hD0D0_0002);
      wr(OPH, 32'h04);
      rd(OUTP, 32'hD0D0_0001, "R9 last slot");
      rd(OUTP, 32'hD0D0_0002, "R9 wrapped slot");
      rd(OUTP, SENT, "R9 empty after wrap");
      rd(OPT, B | 32'hC4, "R9 tail");
      // R10 size code
      wr(CTRL, 32'h33);
      rd(IPH, B | 32'h88, "R10 code1 region");
      wr(CTRL, 32'h3F);
      rd(OPT, B | 32'hC04, "R10 clamp");
      wr(CTRL, 32'h33);
      // R8 ne enable gating
      wr(INP, 32'hB0B0_0003);
      chk("R8 ne set", {31'd0, irq_inpost_ne}, 1);
      wr(CTRL, 32'h23);
      chk("R8 ne gated", {31'd0, irq_inpost_ne}, 0);
      // R11 disabled unit with live queues
      wr(16'h800C, 32'hE0E0_0001);
      wr(IFH, 32'h10);
      wr(CTRL, 32'h22);
      rd(INP, SENT, "R11 no pop");
      wr(OUTP, 32'h77);
      rd(OFH, B | 32'h13C, "R11 no push");
      wr(CTRL, 32'h23);
      rd(INP, 32'hE0E0_0001, "R11 R3 pop after enable");
      repeat (3) @(negedge clk);
      done = 1'b1;
      finish_run();
   end
endmodule